// File: doc/BRIEF.md
# Clock Control Register Bank

The block holds the configuration words of a chip's clock controller: two PLL control words, a clock control word, clock gating words, peripheral divider words, reset status and debug words, voltage-scaling words, load-tracking words, power-management words, a miscellaneous control word and low-power interrupt masks. There are 28 words in all. Each word comes out of reset at a fixed value and can be read and written in full through a simple 32-bit host port. Addresses are byte offsets inside a 4 KiB window.

From the main PLL word and the clock control word the block works out, as plain integers in hertz, the frequencies that the configuration would produce: the main PLL output, the core clock, the bus clock and the peripheral clock. A separate clock-select query input returns the frequency of one named clock, so that timer and baud-rate logic elsewhere can ask for its tick rate. No real clock is generated or gated here. The bank only reports numbers.

Accesses that are out of range, unaligned or narrower than a word are refused in a defined way: nothing is written, a read returns zero, and a one-cycle error pulse is raised.

Top module: `clkctl_regbank`

## Requirements
- R1: After reset every word reads as zero, except these word indices: 0 = 0x800B2C01, 1 = 0x84042800, 2 = 0xD0030000, 3 = 0x028A0100, 4 = 0x04008100, 5 = 0x00000438, 6 to 9 = 0x01010101, 22 = 0x00A00000, 23 = 0x0000A030, 24 = 0x0000A030 and 25 = 0x43000000. The word index is the byte offset divided by 4.
- R2: A legal access is one with `req_valid` high, byte offset below 0x70, offset bits [1:0] equal to 0 and `req_be` equal to 4'hF. A legal write stores all 32 bits of `req_wdata` into the word at that offset at the clock edge. A legal read returns that word on `rd_data`, with `rd_valid` high, in the cycle after the request.
- R3: A read at an offset of 0x70 or above returns `rd_data` = 0 with `rd_valid` high and `acc_err` high in the cycle after the request. A write there changes no word, even when the offset bits [6:2] alias a real index, and it raises `acc_err`.
- R4: An access with offset bits [1:0] not zero, or with `req_be` other than 4'hF, writes nothing, reads as 0 and raises `acc_err` in the cycle after the request.
- R5: With bypass off, `pll_hz` = floor(2 * 24 MHz * (MFI * (MFD + 1) + MFN) / ((MFD + 1) * (PD + 1))), truncated to 32 bits. The fields come from word 0: MFN = bits [9:0], MFI = bits [13:10], MFD = bits [25:16] and PD = bits [29:26].
- R6: An MFI field value below 5 is used as 5.
- R7: When bit 22 of word 2 (the clock control word) is set, `pll_hz` = 24,000,000.
- R8: `core_hz` = S / (1 + word 2 bits [31:30]). S is `pll_hz` when word 2 bit 14 is clear, and floor(`pll_hz` * 3 / 4) when it is set. All divisions are integer floor divisions.
- R9: `bus_hz` = `core_hz` / (1 + word 2 bits [29:28]), and `periph_hz` = floor(`bus_hz` / 2).
- R10: The `query_sel` codes give these results on `query_hz`:
  - 0 gives 0.
  - 1 and 2 give `periph_hz`.
  - 3 gives 32,768.
  - Codes 4 to 7 give 0 with `query_unsup` high.
  - `query_unsup` is low for codes 0 to 3.
- R11: With the reset values, `pll_hz` = 532,000,000, `core_hz` = 133,000,000, `bus_hz` = 66,500,000 and `periph_hz` = 33,250,000.
- R12: `acc_err` is high only in the cycle after a refused access. It stays low after legal accesses and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KiB window |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after a read request |
| rd_data | output | 32 | Read response data |
| acc_err | output | 1 | One-cycle pulse after a refused access |
| query_sel | input | 3 | Clock-select query code |
| pll_hz | output | 32 | Main PLL frequency in Hz |
| core_hz | output | 32 | Core clock frequency in Hz |
| bus_hz | output | 32 | Bus clock frequency in Hz |
| periph_hz | output | 32 | Peripheral clock frequency in Hz |
| query_hz | output | 32 | Frequency of the queried clock in Hz |
| query_unsup | output | 1 | Query code is not supported |

## Verification
The frequency path is tested with several PLL words:
- The reset word, whose fractional MFN/MFD part checks the single exact division.
- A word with a post-divider and no fraction, which checks the PD term.
- A word with a non-trivial fraction and PD = 2, which checks that the fraction and PD are combined correctly.
- MFI values of 0 and 2, which must give the same result as MFI = 5.

The clock control word is tested with bypass on and off, and with the 3/4 source on and off together with non-zero core and bus divider fields. This shows that each field sits at its own bit position and that the divisions are applied in order.

On the host side, the tests cover these cases:
- Writes to the first and last words, which catch decode errors.
- A write to an out-of-range offset whose low index bits alias word 0.
- An unaligned write and a partial-byte write to the clock control word, read back to show they were dropped.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   // number of words with a defined meaning
   localparam int unsigned MAP_WORDS = 28;
   localparam int unsigned QSEL_W    = 3;

   // word indices used by the frequency logic
   localparam int unsigned IX_MAIN_PLL = 0;
   localparam int unsigned IX_CLK_CTL  = 2;

   typedef enum logic [QSEL_W-1:0] {
      CQ_NONE      = 3'd0,
      CQ_PERIPH    = 3'd1,
      CQ_PERIPH_HI = 3'd2,
      CQ_SLOW      = 3'd3
   } clk_query_e;

   // main PLL control word layout
   typedef struct packed {
      logic [1:0]  rsv_top;
      logic [3:0]  post_div;
      logic [9:0]  frac_den;
      logic [1:0]  rsv_mid;
      logic [3:0]  int_mul;
      logic [9:0]  frac_num;
   } pll_word_t;

   // clock control word layout
   typedef struct packed {
      logic [1:0]  core_div;
      logic [1:0]  bus_div;
      logic [4:0]  rsv_a;
      logic        pll_bypass;
      logic [6:0]  rsv_b;
      logic        core_src34;
      logic [13:0] rsv_c;
   } cctl_word_t;

   function automatic logic [31:0] reset_word(input int unsigned idx);
      logic [31:0] v;
      case (idx)
         0:             v = 32'h800B_2C01;
         1:             v = 32'h8404_2800;
         2:             v = 32'hD003_0000;
         3:             v = 32'h028A_0100;
         4:             v = 32'h0400_8100;
         5:             v = 32'h0000_0438;
         6, 7, 8, 9:    v = 32'h0101_0101;
         22:            v = 32'h00A0_0000;
         23, 24:        v = 32'h0000_A030;
         25:            v = 32'h4300_0000;
         default:       v = 32'h0000_0000;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/clkctl_hostif.sv
module clkctl_hostif #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 28,
   localparam int BE_W    = DATA_W / 8,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam int LIMIT   = NUM_REGS * 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] rd_word,
   output logic              wr_en,
   output logic [IDX_W-1:0]  word_idx,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_err
);

   logic aligned, full_word, in_range, legal;

   assign aligned   = (req_addr[1:0] == 2'b00);
   assign full_word = &req_be;
   assign in_range  = (req_addr < ADDR_W'(LIMIT));
   assign legal     = aligned && full_word && in_range;

   assign word_idx  = req_addr[IDX_W+1:2];
   assign wr_en     = req_valid && req_write && legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         acc_err  <= 1'b0;
      end else begin
         rd_valid <= req_valid && !req_write;
         rd_data  <= (req_valid && !req_write && legal) ? rd_word : '0;
         acc_err  <= req_valid && !legal;
      end
   end

endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
   import clkctl_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 28,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] pll_word,
   output logic [DATA_W-1:0] cctl_word
);

   logic [DATA_W-1:0] words [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= DATA_W'(reset_word(g));
         else if (wr_en && (wr_idx == IDX_W'(g)))
            q <= wr_data;
      end
      assign words[g] = q;
   end

   assign rd_word   = (32'(rd_idx) < NUM_REGS) ? words[rd_idx] : '0;
   assign pll_word  = words[IX_MAIN_PLL];
   assign cctl_word = words[IX_CLK_CTL];

endmodule

// File: rtl/clkctl_pll_calc.sv
module clkctl_pll_calc #(
   parameter int REF_HZ  = 24_000_000,
   parameter int FREQ_W  = 32,
   parameter int MFI_MIN = 5
) (
   input  logic [9:0]        frac_num,
   input  logic [3:0]        int_mul,
   input  logic [9:0]        frac_den,
   input  logic [3:0]        post_div,
   input  logic              bypass,
   output logic [FREQ_W-1:0] pll_hz
);

   logic [3:0]  mul_eff;
   logic [63:0] den_frac, numer, denom, quot;

   assign mul_eff  = (int_mul < 4'(MFI_MIN)) ? 4'(MFI_MIN) : int_mul;
   assign den_frac = 64'(frac_den) + 64'd1;
   // one exact division: 2*ref*(MFI*(MFD+1)+MFN) / ((MFD+1)*(PD+1))
   assign numer    = (64'(REF_HZ) * 64'd2) * (64'(mul_eff) * den_frac + 64'(frac_num));
   assign denom    = den_frac * (64'(post_div) + 64'd1);
   assign quot     = numer / denom;

   assign pll_hz   = bypass ? FREQ_W'(REF_HZ) : quot[FREQ_W-1:0];

endmodule

// File: rtl/clkctl_freq_tree.sv
module clkctl_freq_tree
   import clkctl_pkg::*;
#(
   parameter int FREQ_W    = 32,
   parameter int SLOW_HZ   = 32768,
   parameter int FREQ_PIPE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] pll_hz,
   input  logic              core_src34,
   input  logic [1:0]        core_div,
   input  logic [1:0]        bus_div,
   input  logic [QSEL_W-1:0] query_sel,
   output logic [FREQ_W-1:0] core_hz,
   output logic [FREQ_W-1:0] bus_hz,
   output logic [FREQ_W-1:0] periph_hz,
   output logic [FREQ_W-1:0] query_hz,
   output logic              query_unsup
);

   localparam int WW = FREQ_W + 2;

   logic [WW-1:0]     wide_pll, scaled, core_w;
   logic [FREQ_W-1:0] core_c, bus_c, periph_c, query_c;
   logic              unsup_c;

   assign wide_pll = WW'(pll_hz);
   assign scaled   = core_src34 ? ((wide_pll * WW'(3)) >> 2) : wide_pll;
   assign core_w   = scaled / (WW'(core_div) + WW'(1));
   assign core_c   = core_w[FREQ_W-1:0];
   assign bus_c    = core_c / (FREQ_W'(bus_div) + FREQ_W'(1));
   assign periph_c = bus_c >> 1;

   always_comb begin
      query_c = '0;
      unsup_c = 1'b0;
      case (clk_query_e'(query_sel))
         CQ_NONE:                 query_c = '0;
         CQ_PERIPH, CQ_PERIPH_HI: query_c = periph_c;
         CQ_SLOW:                 query_c = FREQ_W'(SLOW_HZ);
         default:                 unsup_c = 1'b1;
      endcase
   end

   if (FREQ_PIPE == 0) begin : g_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign core_hz     = core_c;
      assign bus_hz      = bus_c;
      assign periph_hz   = periph_c;
      assign query_hz    = query_c;
      assign query_unsup = unsup_c;
   end else begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            core_hz     <= '0;
            bus_hz      <= '0;
            periph_hz   <= '0;
            query_hz    <= '0;
            query_unsup <= 1'b0;
         end else begin
            core_hz     <= core_c;
            bus_hz      <= bus_c;
            periph_hz   <= periph_c;
            query_hz    <= query_c;
            query_unsup <= unsup_c;
         end
      end
   end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
   import clkctl_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_REGS  = 28,
   parameter int REF_HZ    = 24_000_000,
   parameter int SLOW_HZ   = 32768,
   parameter int FREQ_W    = 32,
   parameter int FREQ_PIPE = 0,
   localparam int BE_W     = DATA_W / 8,
   localparam int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              acc_err,
   input  logic [QSEL_W-1:0] query_sel,
   output logic [FREQ_W-1:0] pll_hz,
   output logic [FREQ_W-1:0] core_hz,
   output logic [FREQ_W-1:0] bus_hz,
   output logic [FREQ_W-1:0] periph_hz,
   output logic [FREQ_W-1:0] query_hz,
   output logic              query_unsup
);

   initial begin
      assert (DATA_W == 32) else $fatal(1, "field layout needs 32-bit words");
      assert (NUM_REGS > 2 && NUM_REGS <= 2 ** (ADDR_W - 2))
         else $fatal(1, "word count does not fit the window");
      assert (FREQ_W >= 26 && FREQ_W <= 62) else $fatal(1, "frequency width out of range");
      assert (FREQ_PIPE == 0 || FREQ_PIPE == 1) else $fatal(1, "FREQ_PIPE is 0 or 1");
   end

   logic              wr_en;
   logic [IDX_W-1:0]  word_idx;
   logic [DATA_W-1:0] rd_word, pll_word, cctl_word;
   pll_word_t         pw;
   cctl_word_t        cw;
   logic              unused_rsv;

   clkctl_hostif #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .rd_word   (rd_word),
      .wr_en     (wr_en),
      .word_idx  (word_idx),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .acc_err   (acc_err)
   );

   clkctl_regfile #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (word_idx),
      .wr_data   (req_wdata),
      .rd_idx    (word_idx),
      .rd_word   (rd_word),
      .pll_word  (pll_word),
      .cctl_word (cctl_word)
   );

   assign pw = pll_word_t'(pll_word);
   assign cw = cctl_word_t'(cctl_word);
   assign unused_rsv = ^{pw.rsv_top, pw.rsv_mid, cw.rsv_a, cw.rsv_b, cw.rsv_c};

   clkctl_pll_calc #(
      .REF_HZ (REF_HZ),
      .FREQ_W (FREQ_W)
   ) u_pll (
      .frac_num (pw.frac_num),
      .int_mul  (pw.int_mul),
      .frac_den (pw.frac_den),
      .post_div (pw.post_div),
      .bypass   (cw.pll_bypass),
      .pll_hz   (pll_hz)
   );

   clkctl_freq_tree #(
      .FREQ_W    (FREQ_W),
      .SLOW_HZ   (SLOW_HZ),
      .FREQ_PIPE (FREQ_PIPE)
   ) u_tree (
      .clk         (clk),
      .rst_n       (rst_n),
      .pll_hz      (pll_hz),
      .core_src34  (cw.core_src34),
      .core_div    (cw.core_div),
      .bus_div     (cw.bus_div),
      .query_sel   (query_sel),
      .core_hz     (core_hz),
      .bus_hz      (bus_hz),
      .periph_hz   (periph_hz),
      .query_hz    (query_hz),
      .query_unsup (query_unsup)
   );

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 28,
   parameter int FREQ_W   = 32,
   localparam int BE_W    = DATA_W / 8,
   localparam int LIMIT   = NUM_REGS * 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [BE_W-1:0]   req_be,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              acc_err,
   input logic [2:0]        query_sel,
   input logic [FREQ_W-1:0] query_hz,
   input logic              query_unsup
);

   // R2
   legal_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr < ADDR_W'(LIMIT) && req_addr[1:0] == 2'b00
       && req_be == {BE_W{1'b1}}) |=> (rd_valid && !acc_err));

   // R3
   oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr >= ADDR_W'(LIMIT))
      |=> (rd_valid && rd_data == '0 && acc_err));

   // R4
   misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_addr[1:0] != 2'b00 || req_be != {BE_W{1'b1}})) |=> acc_err);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!acc_err && !rd_valid));

   // R10
   qry_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (query_sel == 3'd0) |-> (query_hz == '0 && !query_unsup));

   // R10
   qry_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (query_sel >= 3'd4) |-> (query_unsup && query_hz == '0));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .FREQ_W   (FREQ_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .req_be      (req_be),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .acc_err     (acc_err),
   .query_sel   (query_sel),
   .query_hz    (query_hz),
   .query_unsup (query_unsup)
);

// File: tb/tb_clkctl_regbank.sv
module tb_clkctl_regbank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        acc_err;
   logic [2:0]  query_sel = '0;
   logic [31:0] pll_hz, core_hz, bus_hz, periph_hz, query_hz;
   logic        query_unsup;

   int n_checks = 0;
   int n_err    = 0;

   always #2.5 clk = ~clk;

   clkctl_regbank dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
      .query_sel(query_sel), .pll_hz(pll_hz), .core_hz(core_hz), .bus_hz(bus_hz),
      .periph_hz(periph_hz), .query_hz(query_hz), .query_unsup(query_unsup)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // expected reset contents per R1
   function automatic logic [31:0] exp_reset(input int i);
      case (i)
         0: return 32'h800B2C01;
         1: return 32'h84042800;
         2: return 32'hD0030000;
         3: return 32'h028A0100;
         4: return 32'h04008100;
         5: return 32'h00000438;
         6, 7, 8, 9: return 32'h01010101;
         22: return 32'h00A00000;
         23, 24: return 32'h0000A030;
         25: return 32'h43000000;
         default: return 32'h0;
      endcase
   endfunction

   // frequency model per R5..R9
   function automatic logic [31:0] m_pll(input logic [31:0] mp, input logic [31:0] cc);
      longint unsigned mfi, mfn, mfd, pd, num, den;
      if (cc[22]) return 32'd24_000_000;
      mfn = longint'(mp[9:0]);
      mfi = longint'(mp[13:10]);
      if (mfi < 5) mfi = 5;
      mfd = longint'(mp[25:16]);
      pd  = longint'(mp[29:26]);
      num = 64'd48_000_000 * (mfi * (mfd + 1) + mfn);
      den = (mfd + 1) * (pd + 1);
      return 32'(num / den);
   endfunction

   function automatic logic [31:0] m_core(input logic [31:0] mp, input logic [31:0] cc);
      longint unsigned s;
      s = longint'(m_pll(mp, cc));
      if (cc[14]) s = (s * 3) / 4;
      return 32'(s / (longint'(cc[31:30]) + 1));
   endfunction

   function automatic logic [31:0] m_bus(input logic [31:0] mp, input logic [31:0] cc);
      return m_core(mp, cc) / (32'(cc[29:28]) + 32'd1);
   endfunction

   task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                         input logic [3:0] be, output logic [31:0] rd,
                         output logic rv, output logic er);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_be = '0;
      rd = rd_data; rv = rd_valid; er = acc_err;
   endtask

   task automatic set_cfg(input logic [31:0] mp, input logic [31:0] cc);
      logic [31:0] d; logic v, e;
      access(1'b1, 12'h000, mp, 4'hF, d, v, e);
      access(1'b1, 12'h008, cc, 4'hF, d, v, e);
   endtask

   task automatic chk_freqs(input string rq, input logic [31:0] mp, input logic [31:0] cc);
      logic [31:0] b;
      b = m_bus(mp, cc);
      chk($sformatf("%s pll", rq), 64'(pll_hz), 64'(m_pll(mp, cc)));
      chk($sformatf("%s core", rq), 64'(core_hz), 64'(m_core(mp, cc)));
      chk($sformatf("%s bus", rq), 64'(bus_hz), 64'(b));
      chk($sformatf("R9 periph (%s)", rq), 64'(periph_hz), 64'(b / 2));
   endtask

   task automatic t_reset;
      logic [31:0] d; logic v, e;
      for (int i = 0; i < 28; i++) begin
         access(1'b0, 12'(i * 4), '0, 4'hF, d, v, e);
         chk($sformatf("R1 word %0d", i), 64'(d), 64'(exp_reset(i)));
         chk($sformatf("R12 no error reading word %0d", i), 64'({v, e}), 64'(2'b10));
      end
      chk("R11 pll", 64'(pll_hz), 64'd532_000_000);
      chk("R11 core", 64'(core_hz), 64'd133_000_000);
      chk("R11 bus", 64'(bus_hz), 64'd66_500_000);
      chk("R11 periph", 64'(periph_hz), 64'd33_250_000);
   endtask

   task automatic t_rw;
      logic [31:0] d; logic v, e;
      access(1'b1, 12'h010, 32'hA5A5_5A5A, 4'hF, d, v, e);
      chk("R12 legal write no error", 64'(e), 64'd0);
      access(1'b0, 12'h010, '0, 4'hF, d, v, e);
      chk("R2 word 4 readback", 64'(d), 64'hA5A5_5A5A);
      access(1'b1, 12'h06C, 32'h1234_5678, 4'hF, d, v, e);
      access(1'b0, 12'h06C, '0, 4'hF, d, v, e);
      chk("R2 word 27 readback", 64'(d), 64'h1234_5678);
      chk("R2 read valid", 64'(v), 64'd1);
      access(1'b0, 12'h068, '0, 4'hF, d, v, e);
      chk("R2 word 26 untouched", 64'(d), 64'd0);
   endtask

   task automatic t_range;
      logic [31:0] d; logic v, e;
      access(1'b0, 12'h070, '0, 4'hF, d, v, e);
      chk("R3 read 0x70 data", 64'(d), 64'd0);
      chk("R3 read 0x70 valid+err", 64'({v, e}), 64'(2'b11));
      @(negedge clk);
      chk("R12 error pulse single cycle", 64'(acc_err), 64'd0);
      access(1'b1, 12'h080, 32'hFFFF_FFFF, 4'hF, d, v, e);
      chk("R3 write 0x80 err", 64'(e), 64'd1);
      access(1'b1, 12'hF08, 32'h0000_0000, 4'hF, d, v, e);
      chk("R3 write 0xF08 err", 64'(e), 64'd1);
      access(1'b0, 12'h000, '0, 4'hF, d, v, e);
      chk("R3 aliased word 0 unchanged", 64'(d), 64'h800B_2C01);
      access(1'b0, 12'h008, '0, 4'hF, d, v, e);
      chk("R3 aliased word 2 unchanged", 64'(d), 64'hD003_0000);
   endtask

   task automatic t_align;
      logic [31:0] d; logic v, e;
      access(1'b1, 12'h009, 32'h0, 4'hF, d, v, e);
      chk("R4 unaligned write err", 64'(e), 64'd1);
      access(1'b1, 12'h008, 32'h0, 4'b0011, d, v, e);
      chk("R4 partial write err", 64'(e), 64'd1);
      access(1'b0, 12'h008, '0, 4'hF, d, v, e);
      chk("R4 clock control unchanged", 64'(d), 64'hD003_0000);
      access(1'b0, 12'h00A, '0, 4'hF, d, v, e);
      chk("R4 unaligned read data", 64'(d), 64'd0);
      chk("R4 unaligned read err", 64'(e), 64'd1);
      access(1'b0, 12'h004, '0, 4'b1110, d, v, e);
      chk("R4 partial read data", 64'(d), 64'd0);
      chk("R4 partial read err", 64'(e), 64'd1);
   endtask

   task automatic t_pll;
      logic [31:0] mp;
      mp = (32'd1 << 26) | (32'd10 << 10);
      set_cfg(mp, 32'h0);
      chk("R5 PD=1 MFI=10", 64'(pll_hz), 64'd240_000_000);
      chk_freqs("R5", mp, 32'h0);
      mp = (32'd2 << 26) | (32'd7 << 16) | (32'd6 << 10) | 32'd3;
      set_cfg(mp, 32'h0);
      chk("R5 fraction PD=2", 64'(pll_hz), 64'd102_000_000);
      chk_freqs("R5", mp, 32'h0);
   endtask

   task automatic t_clamp;
      set_cfg(32'd2 << 10, 32'h0);
      chk("R6 MFI=2 clamped", 64'(pll_hz), 64'd240_000_000);
      set_cfg(32'd0, 32'h0);
      chk("R6 MFI=0 clamped", 64'(pll_hz), 64'd240_000_000);
      set_cfg(32'd6 << 10, 32'h0);
      chk("R6 MFI=6 not clamped", 64'(pll_hz), 64'd288_000_000);
   endtask

   task automatic t_bypass;
      logic [31:0] cc;
      cc = (32'd1 << 22) | (32'd1 << 30);
      set_cfg(32'h800B_2C01, cc);
      chk("R7 bypass pll", 64'(pll_hz), 64'd24_000_000);
      chk("R8 bypass core", 64'(core_hz), 64'd12_000_000);
      chk_freqs("R7", 32'h800B_2C01, cc);
   endtask

   task automatic t_src;
      logic [31:0] cc;
      cc = (32'd1 << 14) | (32'd2 << 30) | (32'd3 << 28);
      set_cfg(32'h800B_2C01, cc);
      chk("R8 3/4 source core", 64'(core_hz), 64'd133_000_000);
      chk("R9 bus div 4", 64'(bus_hz), 64'd33_250_000);
      chk("R9 periph", 64'(periph_hz), 64'd16_625_000);
      cc = (32'd1 << 14) | (32'd1 << 28);
      set_cfg(32'h800B_2C01, cc);
      chk_freqs("R8", 32'h800B_2C01, cc);
   endtask

   task automatic t_query;
      for (int q = 0; q < 8; q++) begin
         @(negedge clk);
         query_sel = 3'(q);
         #1;
         if (q == 1 || q == 2)
            chk($sformatf("R10 code %0d", q), 64'({query_unsup, query_hz}), 64'({1'b0, periph_hz}));
         else if (q == 3)
            chk("R10 code 3", 64'({query_unsup, query_hz}), 64'({1'b0, 32'd32768}));
         else if (q == 0)
            chk("R10 code 0", 64'({query_unsup, query_hz}), 64'd0);
         else
            chk($sformatf("R10 code %0d unsupported", q), 64'({query_unsup, query_hz}),
                64'({1'b1, 32'd0}));
      end
      query_sel = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset acc_err", 64'(acc_err), 64'd0);
      chk("R2 reset rd_valid", 64'(rd_valid), 64'd0);
      rst_n = 1'b1;
      t_reset();
      t_query();
      t_rw();
      t_range();
      t_align();
      t_pll();
      t_clamp();
      t_bypass();
      t_src();
      t_query();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule